// File: doc/BRIEF.md
# FIFO Error Monitor with Interrupt Masking

This block guards the host-facing buffers of a data-processing engine. The host loads input words into an input FIFO and drains results from an output FIFO, both over a simple register bus. The engine consumes input words and produces output words through its own strobes. The monitor checks every bus access and every engine event against the FIFO fill state. It records each detected fault as a sticky bit in a status register. A mask register can suppress any fault completely.

Each unmasked fault sets its status bit. The status bit raises one interrupt line and a halt request to the engine. Both stay high until software clears every status bit by writing ones to it. A masked fault leaves no trace. The input FIFO holds 256 bytes (32 words of 64 bits). With no flow control in front of it, any further input overflows it. The output FIFO is a small buffer of 8 words.

Register word addresses are: 0 status (write 1 to clear), 1 mask, 2 data size, 3 input FIFO (write pushes a word; a read returns 0), and 4 output FIFO (read pops a word; a write is ignored). Addresses 5 and above are not decoded. Status and mask use the same layout. Bits are counted with bit 0 as the most significant bit of the 64-bit word.

Top module: `fifo_err_mon`

## Requirements
- R1: After reset the status register and the mask register read 0, err_irq and eng_halt are low, and both FIFOs are empty.
- R2: A fault whose mask bit is 1 leaves its status bit at 0 and does not raise err_irq or eng_halt.
- R3: A write to address 3 while the input FIFO holds 32 words sets the input-overflow bit (bit 61, the value 0x4). The word is dropped and the FIFO contents do not change.
- R4: A read of address 4 while the output FIFO is empty sets the output-underflow bit (bit 62, the value 0x2). The read returns 0 and no word is removed.
- R5: A write to the data-size register (address 2) while the output FIFO holds at least one word sets the output-FIFO bit (bit 58, the value 0x20). The written value is still stored and reads back.
- R6: An eng_done pulse while the input FIFO holds at least one word sets the input-FIFO bit (bit 59, the value 0x10).
- R7: A read or a write at any address from 5 upward sets the address-error bit (bit 57, the value 0x40).
- R8: Status bits are sticky. Writing 1 to a status bit at address 0 clears it. A fault detected in the same cycle as its clear leaves the bit set.
- R9: err_irq and eng_halt are high in the cycle after a status bit becomes set. They stay high for as long as any status bit is set.
- R10: Bits 60 and 63 (the values 0x8 and 0x1) and all bits above 0x40 always read 0 in both status and mask, whatever is written to them.
- R11: Words pushed at address 3 reach eng_in_data in push order, and each eng_pop advances to the next word. Words pushed by the engine are read at address 4 in push order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data, combinational from address |
| eng_pop | input | 1 | Engine takes the head word of the input FIFO |
| eng_in_data | output | 64 | Head word of the input FIFO, 0 when empty |
| eng_push | input | 1 | Engine writes a result word into the output FIFO |
| eng_out_data | input | 64 | Result word from the engine |
| eng_done | input | 1 | Engine done event |
| err_irq | output | 1 | Error interrupt |
| eng_halt | output | 1 | Halt request to the engine |

## Verification
Two events can fall in the same cycle. The engine can signal done with words still queued while the host writes ones to clear the input-FIFO status bit. The bench drives both in one cycle and expects the bit to read back as set, with the interrupt still high. The random phase often pairs engine done and push strobes with status clears and mask writes on the bus. A bench model applies fault-wins-over-clear, so each cycle's interrupt level and each status readback are judged against it.

// File: rtl/fifo_err_mon.sv
module fifo_err_mon #(
  parameter int DATA_W    = 64,
  parameter int IN_BYTES  = 256,
  parameter int OUT_DEPTH = 8,
  parameter int ADDR_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              eng_pop,
  output logic [DATA_W-1:0] eng_in_data,
  input  logic              eng_push,
  input  logic [DATA_W-1:0] eng_out_data,
  input  logic              eng_done,
  output logic              err_irq,
  output logic              eng_halt
);
  localparam int IN_DEPTH = IN_BYTES / (DATA_W / 8);
  localparam int IN_AW    = $clog2(IN_DEPTH);
  localparam int OUT_AW   = $clog2(OUT_DEPTH);

  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_SIZE = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_IN   = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_OUT  = ADDR_W'(4);

  localparam int B_AE  = 6;
  localparam int B_OFE = 5;
  localparam int B_IFE = 4;
  localparam int B_IFO = 2;
  localparam int B_OFU = 1;
  localparam logic [DATA_W-1:0] LIVE = DATA_W'(7'b1110110);

  logic [DATA_W-1:0] in_mem [IN_DEPTH];
  logic [IN_AW-1:0]  in_wp, in_rp;
  logic [IN_AW:0]    in_cnt;
  logic [DATA_W-1:0] out_mem [OUT_DEPTH];
  logic [OUT_AW-1:0] out_wp, out_rp;
  logic [OUT_AW:0]   out_cnt;

  logic [DATA_W-1:0] status_q, mask_q, size_q, ev, clr;

  wire in_full   = in_cnt == (IN_AW+1)'(IN_DEPTH);
  wire in_empty  = in_cnt == '0;
  wire out_full  = out_cnt == (OUT_AW+1)'(OUT_DEPTH);
  wire out_empty = out_cnt == '0;

  wire push_req = bus_wr && bus_addr == A_IN;
  wire pop_req  = bus_rd && bus_addr == A_OUT;
  wire in_push  = push_req && !in_full;
  wire in_pop   = eng_pop && !in_empty;
  wire out_push = eng_push && !out_full;
  wire out_pop  = pop_req && !out_empty;

  always_ff @(posedge clk) begin
    if (in_push) in_mem[in_wp] <= bus_wdata;
    if (out_push) out_mem[out_wp] <= eng_out_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_wp <= '0; in_rp <= '0; in_cnt <= '0;
      out_wp <= '0; out_rp <= '0; out_cnt <= '0;
    end else begin
      if (in_push) in_wp <= in_wp + 1'b1;
      if (in_pop) in_rp <= in_rp + 1'b1;
      in_cnt <= in_cnt + (IN_AW+1)'(in_push) - (IN_AW+1)'(in_pop);
      if (out_push) out_wp <= out_wp + 1'b1;
      if (out_pop) out_rp <= out_rp + 1'b1;
      out_cnt <= out_cnt + (OUT_AW+1)'(out_push) - (OUT_AW+1)'(out_pop);
    end
  end

  always_comb begin
    ev = '0;
    ev[B_IFO] = push_req && in_full;
    ev[B_OFU] = pop_req && out_empty;
    ev[B_OFE] = bus_wr && bus_addr == A_SIZE && !out_empty;
    ev[B_IFE] = eng_done && !in_empty;
    ev[B_AE]  = (bus_wr || bus_rd) && bus_addr > A_OUT;
  end

  assign clr = (bus_wr && bus_addr == A_STAT) ? bus_wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= '0;
      size_q   <= '0;
    end else begin
      status_q <= ((status_q & ~clr) | (ev & ~mask_q)) & LIVE;
      if (bus_wr && bus_addr == A_MASK) mask_q <= bus_wdata & LIVE;
      if (bus_wr && bus_addr == A_SIZE) size_q <= bus_wdata;
    end
  end

  always_comb begin
    case (bus_addr)
      A_STAT:  bus_rdata = status_q;
      A_MASK:  bus_rdata = mask_q;
      A_SIZE:  bus_rdata = size_q;
      A_OUT:   bus_rdata = out_empty ? '0 : out_mem[out_rp];
      default: bus_rdata = '0;
    endcase
  end

  assign eng_in_data = in_empty ? '0 : in_mem[in_rp];
  assign err_irq  = |status_q;
  assign eng_halt = |status_q;
endmodule

module fifo_err_mon_chk #(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              err_irq,
  input logic [DATA_W-1:0] status_q,
  input logic [DATA_W-1:0] mask_q,
  input logic              in_full,
  input logic              out_empty
);
  a_r3_overflow_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(3) && in_full && !mask_q[2]) |=> status_q[2]);

  a_r4_underflow_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADDR_W'(4) && out_empty) |-> bus_rdata == '0);

  a_r2_masked_silent: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_wr || bus_rd) && bus_addr > ADDR_W'(4) && mask_q[6] && !status_q[6]) |=> !status_q[6]);

  a_r7_addr_irq: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_wr || bus_rd) && bus_addr > ADDR_W'(4) && !mask_q[6]) |=> err_irq);

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q[6] && !(bus_wr && bus_addr == ADDR_W'(0) && bus_wdata[6])) |=> status_q[6]);
endmodule

bind fifo_err_mon fifo_err_mon_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .err_irq(err_irq),
  .status_q(status_q), .mask_q(mask_q), .in_full(in_full), .out_empty(out_empty));

// File: tb/fifo_err_mon_test.sv
module fifo_err_mon_test;
  localparam int DW = 64, AW = 4, IND = 32, OUTD = 8;
  localparam logic [63:0] LIVE = 64'h76;

  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic bus_wr = 0, bus_rd = 0, eng_pop = 0, eng_push = 0, eng_done = 0;
  logic [AW-1:0] bus_addr = 0;
  logic [DW-1:0] bus_wdata = 0, eng_out_data = 0;
  logic [DW-1:0] bus_rdata, eng_in_data;
  logic err_irq, eng_halt;

  fifo_err_mon uut (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .eng_pop(eng_pop), .eng_in_data(eng_in_data), .eng_push(eng_push),
    .eng_out_data(eng_out_data), .eng_done(eng_done), .err_irq(err_irq),
    .eng_halt(eng_halt));

  int checks = 0, errors = 0;
  logic [63:0] m_st = 0, m_mask = 0, m_size = 0;
  logic [63:0] q_in[$], q_out[$];

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] fault_bits(input logic wr, rd, input logic [AW-1:0] a,
                                             input logic dn);
    logic [63:0] ev = 0;
    if (wr && a == 3 && q_in.size() == IND) ev[2] = 1;
    if (rd && a == 4 && q_out.size() == 0) ev[1] = 1;
    if (wr && a == 2 && q_out.size() != 0) ev[5] = 1;
    if (dn && q_in.size() != 0) ev[4] = 1;
    if ((wr || rd) && a > 4) ev[6] = 1;
    return ev;
  endfunction

  task automatic cyc(input logic wr, rd, input logic [AW-1:0] a, input logic [63:0] wd,
                     input logic ep, epu, input logic [63:0] ed, input logic dn,
                     input string tag);
    logic [63:0] ev, exp_rd;
    logic pin, pout, din, dout;
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd;
    eng_pop = ep; eng_push = epu; eng_out_data = ed; eng_done = dn;
    #1;
    if (rd) begin
      case (a)
        0: exp_rd = m_st;
        1: exp_rd = m_mask;
        2: exp_rd = m_size;
        4: exp_rd = (q_out.size() != 0) ? q_out[0] : 64'h0;
        default: exp_rd = 0;
      endcase
      chk({tag, " rdata"}, bus_rdata, exp_rd);
    end
    if (ep && q_in.size() != 0) chk({tag, " R11 eng_in_data"}, eng_in_data, q_in[0]);
    ev = fault_bits(wr, rd, a, dn);
    pin = wr && a == 3 && q_in.size() < IND;
    din = ep && q_in.size() != 0;
    pout = epu && q_out.size() < OUTD;
    dout = rd && a == 4 && q_out.size() != 0;
    if (din) void'(q_in.pop_front());
    if (pin) q_in.push_back(wd);
    if (dout) void'(q_out.pop_front());
    if (pout) q_out.push_back(ed);
    m_st = ((m_st & ~((wr && a == 0) ? wd : 64'h0)) | (ev & ~m_mask)) & LIVE;
    if (wr && a == 1) m_mask = wd & LIVE;
    if (wr && a == 2) m_size = wd;
    @(posedge clk);
    @(negedge clk);
    chk({tag, " R9 irq"}, 64'(err_irq), 64'(|m_st));
    chk({tag, " R9 halt"}, 64'(eng_halt), 64'(|m_st));
    bus_wr = 0; bus_rd = 0; eng_pop = 0; eng_push = 0; eng_done = 0;
  endtask

  task automatic wr_reg(input logic [AW-1:0] a, input logic [63:0] d, input string tag);
    cyc(1, 0, a, d, 0, 0, 0, 0, tag);
  endtask
  task automatic rd_reg(input logic [AW-1:0] a, input string tag);
    cyc(0, 1, a, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1 irq", 64'(err_irq), 0);
    chk("R1 halt", 64'(eng_halt), 0);
    rd_reg(0, "R1 status");
    rd_reg(1, "R1 mask");
    cyc(0, 0, 0, 0, 1, 0, 0, 1, "R1 done on empty input");

    for (int i = 0; i < IND; i++) wr_reg(3, 64'hA000 + 64'(i), "R11 fill");
    chk("R3 no fault yet", 64'(err_irq), 0);
    wr_reg(3, 64'hDEAD, "R3 overflow push");
    rd_reg(0, "R3 status");
    chk("R3 bit", m_st, 64'h4);
    for (int i = 0; i < IND; i++) begin
      chk("R11 order", eng_in_data, 64'hA000 + 64'(i));
      cyc(0, 0, 0, 0, 1, 0, 0, 0, "R11 drain");
    end
    chk("R3 dropped word absent", eng_in_data, 0);
    wr_reg(0, 64'h4, "R8 clear");
    rd_reg(0, "R8 status cleared");

    rd_reg(4, "R4 underflow");
    rd_reg(0, "R4 status");
    wr_reg(0, '1, "R8 clear all");

    cyc(0, 0, 0, 0, 0, 1, 64'h1111, 0, "R11 engine push");
    cyc(0, 0, 0, 0, 0, 1, 64'h2222, 0, "R11 engine push");
    wr_reg(2, 64'h40, "R5 size write");
    rd_reg(0, "R5 status");
    rd_reg(2, "R5 size readback");
    rd_reg(4, "R11 out first");
    rd_reg(4, "R11 out second");
    wr_reg(0, '1, "R8 clear all");

    wr_reg(3, 64'h5, "R6 load one");
    cyc(1, 0, 0, 64'h10, 0, 0, 0, 1, "R8 R6 done with clear");
    rd_reg(0, "R6 status kept");
    cyc(0, 0, 0, 0, 1, 0, 0, 0, "R6 drain");
    wr_reg(0, '1, "R8 clear all");

    wr_reg(1, '1, "R10 mask all ones");
    rd_reg(1, "R10 mask readback");
    cyc(0, 1, 9, 0, 0, 0, 0, 0, "R2 masked addr error");
    rd_reg(4, "R2 masked underflow");
    rd_reg(0, "R2 status stays zero");
    wr_reg(1, 0, "R2 unmask");

    cyc(0, 1, 12, 0, 0, 0, 0, 0, "R7 read bad addr");
    wr_reg(0, '1, "R8 clear");
    cyc(1, 0, 7, 64'h1, 0, 0, 0, 0, "R7 write bad addr");
    rd_reg(0, "R7 R10 status");
    wr_reg(0, '1, "R8 clear all");

    for (int n = 0; n < 4000; n++) begin
      logic wr, rd, ep, epu, dn;
      logic [AW-1:0] a;
      logic [63:0] wd;
      int op = int'($urandom_range(0, 9));
      a = AW'($urandom_range(0, 7));
      wr = op < 4;
      rd = op >= 4 && op < 7;
      if (wr && a == 0) wd = ($urandom_range(0, 3) == 0) ? 64'({$urandom, $urandom}) : '1;
      else if (wr && a == 1) wd = ($urandom_range(0, 1) == 0) ? 64'h0 : 64'({$urandom, $urandom});
      else wd = 64'({$urandom, $urandom});
      if (!wr && !rd && $urandom_range(0, 1) == 1) begin
        wr = 1; a = 3;
      end
      ep = $urandom_range(0, 5) == 0;
      epu = $urandom_range(0, 3) == 0;
      dn = $urandom_range(0, 15) == 0;
      cyc(wr, rd, a, wd, ep, epu, 64'({$urandom, $urandom}), dn, "R9 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule